// File: doc/BRIEF.md
# ALU Control Decoder with 32-bit ALU

This block turns a two-bit operation class from the main instruction control, together with the six-bit function field of a register-format instruction, into a three-bit ALU operation code, and then runs that operation on two 32-bit operands. The code has one bit that inverts the second operand (with carry-in set) and two bits that pick the result source. The decoder is a minimised two-level sum of products in which unused function codes are don't-cares, so it is not a full lookup table.

The ALU offers bitwise AND, bitwise OR, add, subtract and set-on-less-than, and reports a zero flag on the result. Everything is combinational. There are no registers and no state. A datapath uses it to compute load/store addresses (class 00), to compare operands for branch-equal (class 01) and to execute register-format arithmetic (class 10).

Top module: `alu_ctl_unit`

## Requirements
- R1: With alu_op = 00, op_code is 010 (add) for every funct value.
- R2: With alu_op = 01, op_code is 110 (subtract) for every funct value.
- R3: With alu_op = 10, funct low nibble 0000 gives 010, 0010 gives 110, 1010 gives 111, 0100 gives 000 and 0101 gives 001.
- R4: funct bits 5 and 4 have no effect on op_code for any alu_op.
- R5: op_code encodings are 000 AND, 001 OR, 010 add, 110 subtract, 111 set-on-less-than; bit 2 inverts opnd_b and sets carry-in.
- R6: Code 000 gives opnd_a & opnd_b, and code 001 gives opnd_a | opnd_b.
- R7: Code 010 gives opnd_a + opnd_b modulo 2^32.
- R8: Code 110 gives opnd_a - opnd_b modulo 2^32, formed as opnd_a + ~opnd_b + 1.
- R9: Code 111 gives bit 0 equal to bit 31 of (opnd_a - opnd_b) and all other bits 0.
- R10: zero is 1 exactly when all 32 result bits are 0.
- R11: All outputs are combinational and follow the inputs with no clock latency.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| alu_op | input | 2 | Operation class from main control |
| funct | input | 6 | Function field of the instruction |
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand |
| op_code | output | 3 | Decoded operation {invert_b, sel[1:0]} |
| result | output | 32 | ALU result |
| zero | output | 1 | High when result is all zeros |

## Verification
A wrong product term in the decoder shows immediately on op_code for the specific class/funct pair that exercises it, and then corrupts result in the same evaluation, so every legal pair is visited directly. A fault in the operand inversion or carry-in shows as an off-by-one or bit-inverted difference on subtract and as a wrong sign decision on set-on-less-than, most visibly for equal operands and for operands near the sign boundary. Because nothing is stored, any fault appears within the same cycle the inputs are applied.

// File: rtl/alu_ctl_pkg.sv
package alu_ctl_pkg;
    localparam int OP_W    = 3;
    localparam int CLASS_W = 2;
    localparam int FUNCT_W = 6;

    typedef enum logic [OP_W-1:0] {
        OP_AND = 3'b000,
        OP_OR  = 3'b001,
        OP_ADD = 3'b010,
        OP_SUB = 3'b110,
        OP_SLT = 3'b111
    } alu_code_e;

    typedef enum logic [1:0] {
        SEL_AND = 2'b00,
        SEL_OR  = 2'b01,
        SEL_SUM = 2'b10,
        SEL_LT  = 2'b11
    } res_sel_e;
endpackage

// File: rtl/alu_op_decoder.sv
module alu_op_decoder
    import alu_ctl_pkg::*;
(
    input  logic [CLASS_W-1:0] op_class,
    input  logic [3:0]         fn_lo,
    output logic [OP_W-1:0]    op_code
);
    logic invert_b, sel_hi, sel_lo;

    // two-level sum of products, unused funct codes are don't-cares
    assign invert_b = op_class[0] | (op_class[1] & fn_lo[1]);
    assign sel_lo   = (op_class[1] & fn_lo[0]) | (op_class[1] & fn_lo[3]);
    assign sel_hi   = ~op_class[1] | ~fn_lo[2];

    assign op_code = {invert_b, sel_hi, sel_lo};

    always_comb begin
        if (op_class == 2'b00)
            a_r1_class0_add: assert (op_code == OP_ADD) else $error("R1 decode");
        if (op_class == 2'b01)
            a_r2_class1_sub: assert (op_code == OP_SUB) else $error("R2 decode");
    end
endmodule

// File: rtl/alu_datapath.sv
module alu_datapath
    import alu_ctl_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [OP_W-1:0]  op_code,
    input  logic [WIDTH-1:0] opnd_a,
    input  logic [WIDTH-1:0] opnd_b,
    output logic [WIDTH-1:0] result
);
    localparam int MSB = WIDTH - 1;

    logic             inv;
    res_sel_e         sel;
    logic [WIDTH-1:0] b_eff;
    logic [WIDTH-1:0] sum;
    logic             less;

    assign inv   = op_code[2];
    assign sel   = res_sel_e'(op_code[1:0]);
    assign b_eff = inv ? ~opnd_b : opnd_b;
    assign sum   = opnd_a + b_eff + WIDTH'(inv);
    assign less  = sum[MSB];

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        logic lt_bit;
        if (i == 0) begin : g_lsb
            assign lt_bit = less;
        end else begin : g_up
            assign lt_bit = 1'b0;
        end
        always_comb begin
            unique case (sel)
                SEL_AND: result[i] = opnd_a[i] & b_eff[i];
                SEL_OR:  result[i] = opnd_a[i] | b_eff[i];
                SEL_SUM: result[i] = sum[i];
                SEL_LT:  result[i] = lt_bit;
                default: result[i] = 1'b0;
            endcase
        end
    end

    always_comb begin
        if (op_code == OP_SLT)
            a_r9_slt_upper_clear: assert (result[MSB:1] == '0) else $error("R9 upper bits");
    end
endmodule

// File: rtl/zero_detect.sv
module zero_detect #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] value,
    output logic             is_zero
);
    assign is_zero = ~|value;
endmodule

// File: rtl/alu_ctl_unit.sv
module alu_ctl_unit
    import alu_ctl_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [CLASS_W-1:0] alu_op,
    input  logic [FUNCT_W-1:0] funct,
    input  logic [WIDTH-1:0]   opnd_a,
    input  logic [WIDTH-1:0]   opnd_b,
    output logic [OP_W-1:0]    op_code,
    output logic [WIDTH-1:0]   result,
    output logic               zero
);
    logic unused_fn_hi;
    assign unused_fn_hi = ^funct[FUNCT_W-1:4];

    alu_op_decoder u_dec (
        .op_class (alu_op),
        .fn_lo    (funct[3:0]),
        .op_code  (op_code)
    );

    alu_datapath #(.WIDTH(WIDTH)) u_path (
        .op_code (op_code),
        .opnd_a  (opnd_a),
        .opnd_b  (opnd_b),
        .result  (result)
    );

    zero_detect #(.WIDTH(WIDTH)) u_zero (
        .value   (result),
        .is_zero (zero)
    );

    always_comb begin
        if (op_code == OP_SUB && opnd_a == opnd_b)
            a_r10_equal_sub_zero: assert (zero) else $error("R10 equal operands");
        if (op_code == OP_AND)
            a_r6_and_subset: assert ((result & ~opnd_a) == '0) else $error("R6 and");
    end
endmodule

// File: tb/alu_ctl_unit_tb.sv
module alu_ctl_unit_tb;
    localparam int W = 32;

    logic         clk = 1'b0;
    logic [1:0]   alu_op;
    logic [5:0]   funct;
    logic [W-1:0] opnd_a, opnd_b;
    logic [2:0]   op_code;
    logic [W-1:0] result;
    logic         zero;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    alu_ctl_unit #(.WIDTH(W)) u_dut (
        .alu_op (alu_op), .funct (funct), .opnd_a (opnd_a), .opnd_b (opnd_b),
        .op_code (op_code), .result (result), .zero (zero)
    );

    function automatic logic [2:0] exp_code(input logic [1:0] cls, input logic [3:0] lo);
        if (cls == 2'b00) return 3'b010;
        if (cls == 2'b01) return 3'b110;
        case (lo)
            4'b0000: return 3'b010;
            4'b0010: return 3'b110;
            4'b1010: return 3'b111;
            4'b0100: return 3'b000;
            default: return 3'b001;
        endcase
    endfunction

    function automatic logic [W-1:0] exp_res(input logic [2:0] c, input logic [W-1:0] a, input logic [W-1:0] b);
        logic [W-1:0] d;
        d = a - b;
        case (c)
            3'b000:  return a & b;
            3'b001:  return a | b;
            3'b010:  return a + b;
            3'b110:  return d;
            default: return {{(W-1){1'b0}}, d[W-1]};
        endcase
    endfunction

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic apply(input logic [1:0] c, input logic [5:0] f, input logic [W-1:0] a, input logic [W-1:0] b);
        @(posedge clk);
        alu_op = c; funct = f; opnd_a = a; opnd_b = b;
        @(negedge clk);
    endtask

    // run one ALU case through class 10 with a legal funct
    task automatic alu_case(input logic [3:0] lo, input logic [W-1:0] a, input logic [W-1:0] b, input string req);
        logic [2:0]   c;
        logic [W-1:0] r;
        c = exp_code(2'b10, lo);
        r = exp_res(c, a, b);
        apply(2'b10, {2'b10, lo}, a, b);
        chk(req, W'(op_code), W'(c));
        chk(req, result, r);
        chk("R10", W'(zero), W'(r == '0));
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog act=timeout exp=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        logic [3:0] legal [5];
        int seed;
        legal = '{4'b0000, 4'b0010, 4'b1010, 4'b0100, 4'b0101};
        seed = $urandom(32'd1234);
        alu_op = 2'b00; funct = '0; opnd_a = '0; opnd_b = '0;
        #1;
        // R11: outputs present with no clock edge yet
        chk("R11 initial add", W'(op_code), 32'd2);
        chk("R11 zero", W'(zero), 32'd1);

        // R1, R2, R4: every funct under classes 00 and 01
        for (int f = 0; f < 64; f++) begin
            apply(2'b00, 6'(f), 32'd7, 32'd5);
            chk("R1", W'(op_code), 32'b010);
            chk("R7 class0", result, 32'd12);
            apply(2'b01, 6'(f), 32'd7, 32'd5);
            chk("R2", W'(op_code), 32'b110);
            chk("R8 class1", result, 32'd2);
        end

        // R3, R4, R5: legal funct codes with every value of bits 5:4
        for (int k = 0; k < 5; k++) begin
            for (int h = 0; h < 4; h++) begin
                apply(2'b10, {2'(h), legal[k]}, '0, '0);
                chk("R3/R4/R5", W'(op_code), W'(exp_code(2'b10, legal[k])));
            end
        end

        // directed corners
        alu_case(4'b0010, 32'h1234_5678, 32'h1234_5678, "R8 equal");
        alu_case(4'b0000, 32'hFFFF_FFFF, 32'h0000_0001, "R7 wrap");
        alu_case(4'b1010, 32'h8000_0000, 32'h0000_0001, "R9 neg<pos");
        alu_case(4'b1010, 32'h0000_0001, 32'h8000_0000, "R9 pos-neg");
        alu_case(4'b1010, 32'd5, 32'd5, "R9 equal");
        alu_case(4'b1010, 32'd3, 32'd9, "R9 small");
        alu_case(4'b0100, 32'hF0F0_F0F0, 32'h0F0F_0F0F, "R6 and");
        alu_case(4'b0101, 32'hF0F0_0000, 32'h0000_0F0F, "R6 or");
        alu_case(4'b0010, 32'd0, 32'd1, "R8 borrow");

        // random operands across all five operations
        for (int n = 0; n < 3000; n++) begin
            logic [3:0] lo;
            logic [W-1:0] a, b;
            lo = legal[$urandom_range(4, 0)];
            a = $urandom();
            b = (n % 7 == 0) ? a : $urandom();
            alu_case(lo, a, b, "R6/R7/R8/R9 random");
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule